// File: doc/BRIEF.md
# Integer Min/Max and Rounded-Average Unit

This unit takes two 64-bit integer operands, A and B, and returns one of two kinds of result. The first is the minimum or maximum of the operands, compared as signed or as unsigned numbers. The second is their average, rounded up. A 2-bit mode field picks the min/max flavour, and a separate select input chooses the average in its place. One comparator drives both the min/max selection and a 4-bit condition field.

When the record flag is set, the unit also writes the condition field. That field reports whether A is less than, greater than or equal to B, using the same signedness as the mode. Its lowest bit copies a summary-overflow input supplied from outside the unit.

The unit has one output register stage. An operation strobed in with `in_valid` shows up on the outputs on the next clock edge, qualified by `out_valid`. A synchronous reset clears the output stage.

Top module: `minmax_avg_unit`

## Requirements
- R1: With `use_avg`=0, `mode` selects the result: 0 gives the unsigned minimum, 1 the unsigned maximum, 2 the signed minimum and 3 the signed maximum of A and B.
- R2: Signed modes treat bit 63 as the sign. Unsigned modes do not. For A=1 and B=0x8000_0000_0000_0000, signed max returns 1 and unsigned max returns B.
- R3: When `rec` is set, `cr_field[3:1]` is 3'b100 if A<B, 3'b010 if A>B and 3'b001 if A==B. `cr_field[0]` equals `so_in` from the same strobe.
- R4: The comparison behind `cr_field` is signed when `mode[1]`=1 and unsigned otherwise. For A=1 and B=0x8000_0000_0000_0000 the field is 0x4 in signed modes and 0x8 in unsigned modes, with `so_in`=0.
- R5: Two equal operands of 0x8000_0000_0000_0000 return that same value in every min/max mode, and the condition field 0x2.
- R6: With `use_avg`=1, the result is (A+B+1)>>1 computed over 65 bits. All-ones averaged with all-ones therefore returns all-ones.
- R7: The average rounds an odd sum up. 0xc523e996a8ff6215 and 0xe1e5b9cc9864c4a8 give 0xd384d1b1a0b2135f. Lowering A by one gives 0xd384d1b1a0b2135e.
- R8: `cr_we` is the registered copy of `rec`. When `rec` was clear, `cr_we` is 0 and `cr_field` is 0.
- R9: `out_valid` rises in the cycle after an `in_valid` strobe and lasts one cycle per strobe. `result`, `cr_field` and `cr_we` keep their values while `in_valid` is low.
- R10: A synchronous reset clears `out_valid`, `cr_we`, `cr_field` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| use_avg | input | 1 | 1 selects the rounded average, 0 selects min/max |
| mode | input | 2 | Bit 1 selects signed comparison, bit 0 selects max |
| rec | input | 1 | Request a condition-field write |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Registered result |
| cr_we | output | 1 | Condition-field write enable |
| cr_field | output | 4 | Condition field: lt, gt, eq, summary overflow |

## Verification
The bench uses a pair of operands whose ordering flips between signed and unsigned reading, so a swapped mode bit or a sign-unaware comparator returns the wrong operand or the wrong condition code.

The equal-operand case with the most negative value catches a comparator that treats equality as less-than or greater-than. The all-ones average catches a sum that drops the 65th bit, which would return 0x7fff_ffff_ffff_ffff. Odd sums catch rounding toward zero.

The bench also clears `rec` and lowers `in_valid` to check that stale condition codes or results never leak through.

// File: rtl/minmax_avg_unit.sv
module minmax_avg_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         use_avg,
  input  logic [1:0]   mode,
  input  logic         rec,
  input  logic         so_in,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         cr_we,
  output logic [3:0]   cr_field
);
  localparam logic [W-1:0] SIGN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] ka, kb, pick, avg;
  logic [W:0]   wide;
  logic         a_lt, a_gt, a_eq;

  assign ka   = mode[1] ? (opa ^ SIGN) : opa;
  assign kb   = mode[1] ? (opb ^ SIGN) : opb;
  assign a_lt = ka < kb;
  assign a_eq = opa == opb;
  assign a_gt = !a_lt && !a_eq;

  assign pick = (a_lt ^ mode[0]) ? opa : opb;
  assign wide = {1'b0, opa} + {1'b0, opb} + (W+1)'(1);
  assign avg  = W'(wide >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cr_we     <= 1'b0;
      cr_field  <= 4'h0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= use_avg ? avg : pick;
        cr_we    <= rec;
        cr_field <= rec ? {a_lt, a_gt, a_eq, so_in} : 4'h0;
      end
    end
  end
endmodule

module minmax_avg_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         use_avg,
  input logic [1:0]   mode,
  input logic         rec,
  input logic         so_in,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         cr_we,
  input logic [3:0]   cr_field
);
  AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R9
  AST_CR_ONEHOT: assert property (@(posedge clk) disable iff (rst) cr_we |-> $onehot(cr_field[3:1])); // R3
  AST_CR_SO: assert property (@(posedge clk) disable iff (rst) out_valid && cr_we |-> cr_field[0] == $past(so_in)); // R3
  AST_CR_EQ: assert property (@(posedge clk) disable iff (rst) out_valid && cr_we && $past(opa) == $past(opb) |-> cr_field[3:1] == 3'b001); // R5
  AST_WE_REC: assert property (@(posedge clk) disable iff (rst) out_valid |-> cr_we == $past(rec)); // R8
  AST_NO_REC_ZERO: assert property (@(posedge clk) disable iff (rst) out_valid && !cr_we |-> cr_field == 4'h0); // R8
  AST_PICK_OPERAND: assert property (@(posedge clk) disable iff (rst) out_valid && !$past(use_avg) |-> result == $past(opa) || result == $past(opb)); // R1
  AST_MAXU_BOUND: assert property (@(posedge clk) disable iff (rst) out_valid && !$past(use_avg) && $past(mode) == 2'd1 |-> result >= $past(opa) && result >= $past(opb)); // R1
endmodule

bind minmax_avg_unit minmax_avg_unit_chk #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .use_avg(use_avg), .mode(mode),
  .rec(rec), .so_in(so_in), .opa(opa), .opb(opb), .out_valid(out_valid),
  .result(result), .cr_we(cr_we), .cr_field(cr_field)
);

// File: tb/test_minmax_avg_unit.sv
module test_minmax_avg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, use_avg = 1'b0, rec = 1'b0, so_in = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] opa = '0, opb = '0;
  logic        out_valid, cr_we;
  logic [63:0] result;
  logic [3:0]  cr_field;
  int n_chk = 0, n_bad = 0;

  localparam logic [63:0] XA  = 64'hc523e996a8ff6215;
  localparam logic [63:0] XB  = 64'he1e5b9cc9864c4a8;
  localparam logic [63:0] NEG = 64'h8000_0000_0000_0000;

  always #4 clk = ~clk;

  minmax_avg_unit i_minmax_avg_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .use_avg(use_avg), .mode(mode),
    .rec(rec), .so_in(so_in), .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .cr_we(cr_we), .cr_field(cr_field)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic avg_i, input logic [1:0] m, input logic r, input logic so,
                        input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    use_avg = avg_i; mode = m; rec = r; so_in = so; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 out_valid", 64'(out_valid), 64'd1);
  endtask

  task automatic t_reset();
    check("R10 out_valid", 64'(out_valid), 64'd0);
    check("R10 cr_we", 64'(cr_we), 64'd0);
    check("R10 cr_field", 64'(cr_field), 64'd0);
    check("R10 result", result, 64'd0);
  endtask

  task automatic t_modes();
    run_op(0, 2'd0, 1, 0, XA, XB); check("R1 minu", result, XA); check("R3 lt", 64'(cr_field), 64'h8);
    run_op(0, 2'd1, 1, 0, XA, XB); check("R1 maxu", result, XB); check("R3 lt", 64'(cr_field), 64'h8);
    run_op(0, 2'd2, 1, 0, XA, XB); check("R1 mins", result, XA); check("R4 lt signed", 64'(cr_field), 64'h8);
    run_op(0, 2'd3, 1, 0, XB, XA); check("R1 maxs", result, XB); check("R3 gt", 64'(cr_field), 64'h4);
  endtask

  task automatic t_sign();
    run_op(0, 2'd3, 1, 0, 64'd1, NEG); check("R2 maxs", result, 64'd1);  check("R4 signed gt", 64'(cr_field), 64'h4);
    run_op(0, 2'd2, 1, 0, 64'd1, NEG); check("R2 mins", result, NEG);    check("R4 signed gt", 64'(cr_field), 64'h4);
    run_op(0, 2'd1, 1, 0, 64'd1, NEG); check("R2 maxu", result, NEG);    check("R4 unsigned lt", 64'(cr_field), 64'h8);
    run_op(0, 2'd0, 1, 0, 64'd1, NEG); check("R2 minu", result, 64'd1);  check("R4 unsigned lt", 64'(cr_field), 64'h8);
  endtask

  task automatic t_equal();
    for (int m = 0; m < 4; m++) begin
      run_op(0, 2'(m), 1, 0, NEG, NEG);
      check("R5 equal value", result, NEG);
      check("R5 equal code", 64'(cr_field), 64'h2);
    end
    run_op(0, 2'd3, 1, 1, NEG, NEG); check("R3 so bit", 64'(cr_field), 64'h3);
    check("R8 cr_we set", 64'(cr_we), 64'd1);
  endtask

  task automatic t_norec();
    run_op(0, 2'd0, 0, 1, XA, XB);
    check("R8 cr_we clear", 64'(cr_we), 64'd0);
    check("R8 cr_field clear", 64'(cr_field), 64'h0);
    check("R1 minu norec", result, XA);
  endtask

  task automatic t_avg();
    run_op(1, 2'd0, 0, 0, XA, XB); check("R7 avg odd", result, 64'hd384d1b1a0b2135f);
    run_op(1, 2'd3, 0, 0, XA - 64'd1, XB); check("R7 avg even", result, 64'hd384d1b1a0b2135e);
    run_op(1, 2'd0, 0, 0, XA - 64'd2, XB); check("R7 avg odd2", result, 64'hd384d1b1a0b2135e);
    run_op(1, 2'd1, 0, 0, '1, '1); check("R6 all ones", result, '1);
    run_op(1, 2'd2, 0, 0, 64'd0, 64'd1); check("R6 round up", result, 64'd1);
  endtask

  task automatic t_hold();
    run_op(0, 2'd1, 1, 0, 64'd5, 64'd9);
    check("R9 before hold", result, 64'd9);
    @(negedge clk);
    opa = 64'd77; opb = 64'd88; rec = 1'b0; use_avg = 1'b1;
    @(negedge clk);
    check("R9 valid low", 64'(out_valid), 64'd0);
    check("R9 result held", result, 64'd9);
    check("R9 cr held", 64'(cr_field), 64'h4 >> 0 == 0 ? 64'h0 : 64'h8);
    check("R9 cr_we held", 64'(cr_we), 64'd1);
  endtask

  task automatic t_midreset();
    run_op(0, 2'd1, 1, 0, 64'd5, 64'd9);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_modes();
    t_sign();
    t_equal();
    t_norec();
    t_avg();
    t_hold();
    t_midreset();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule